// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the output raster for a scaled video stream driving a display panel. Two free-running counters walk every pixel position of a frame: a horizontal counter over the pixels of a line and a vertical counter over the lines of a frame. From the counter positions and a set of programmed positions, the block derives horizontal and vertical sync, a vertical blanking flag, a data-enable and one-clock strobes that mark where the start-of-active-video and end-of-active-video reference codes begin. The code slots are four clocks wide, so active pixels begin four clocks after the start-code position and end at the end-code position.

The timing set has ten fields. A write strobe captures a new set into a pending copy, and that copy becomes the active set only at the frame boundary, so a frame is never built from two timing sets. A group of four sticky error flags reports inconsistencies in the active set. Software clears the flags by toggling a control input. A flag that comes back after the clear shows that the programmed raster cannot be realised.

A synchronous active-low reset zeroes both counters and every output and loads a default timing set given by parameters. The default set describes a 1024 x 600 panel with 1344 clocks per line and 625 lines per frame.

Top module: `raster_timing_gen`

## Requirements
- R1: `hcnt` counts 0, 1, ..., `htotal`-1 and then returns to 0. `vcnt` rises by one each time `hcnt` returns to 0, and returns to 0 after `vtotal`-1.
- R2: `hsync` is 1 exactly when `hcnt` < `hs_end`.
- R3: `vsync` is 1 exactly when `vcnt` < `vs_end`.
- R4: `vblank` is 1 when `vcnt` lies in the window that opens at `vbi_start` and closes just before `vbi_end`. If `vbi_start` > `vbi_end`, the window wraps through line 0 (`vcnt` >= `vbi_start` or `vcnt` < `vbi_end`).
- R5: `sav_stb` is 1 exactly when `hcnt` == `sav`, and `eav_stb` is 1 exactly when `hcnt` == `eav`.
- R6: `de` is 1 exactly when `sav`+4 <= `hcnt` < `eav` and `vblank` is 0.
- R7: A pulse on `cfg_wr` captures all `cfg_*` inputs into a pending set. The pending set becomes active at the clock edge where the counters return from the last position of the frame to (0,0). The new set governs the outputs from that (0,0) cycle onward. The current frame is unaffected, and a later write before the boundary replaces an earlier one.
- R8: `err_flags` bits are sticky and reflect the timing set that governs the same cycle. Bit 0: `eav` >= `htotal`. Bit 1: `sav`+4+`hact` != `eav`, or `hs_end` > `sav`. Bit 2: `vact` plus the blanking length exceeds `vtotal`; the blanking length is `vbi_end`-`vbi_start`, or `vtotal`-`vbi_start`+`vbi_end` when the window wraps. Bit 3: `vs_end` > `vtotal`, or `vbi_start` >= `vtotal`, or `vbi_end` > `vtotal`.
- R9: A change of level on `err_clr_tgl`, in either direction, clears all flags at the next edge. A condition that still holds sets its flag again one edge later.
- R10: While `rst_n` is 0 at a clock edge, both counters, all outputs and the flags become 0. The default timing set becomes active and any pending set is discarded.
- R11: Counters and all outputs are registered and describe the same pixel position in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Capture the cfg_* inputs into the pending set |
| cfg_htotal | input | 13 | Clocks per line |
| cfg_hact | input | 12 | Active pixels per line |
| cfg_hs_end | input | 13 | Horizontal position where hsync ends |
| cfg_sav | input | 13 | Position of the start-of-active code |
| cfg_eav | input | 13 | Position of the end-of-active code |
| cfg_vtotal | input | 12 | Lines per frame |
| cfg_vact | input | 12 | Active lines per frame |
| cfg_vs_end | input | 11 | Line where vsync ends |
| cfg_vbi_start | input | 12 | First blanking line |
| cfg_vbi_end | input | 12 | Line after the last blanking line |
| err_clr_tgl | input | 1 | Toggle to clear the error flags |
| hcnt | output | 13 | Horizontal position |
| vcnt | output | 12 | Vertical position |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| vblank | output | 1 | Vertical blanking interval |
| de | output | 1 | Active pixel enable |
| sav_stb | output | 1 | First clock of the start-of-active code slot |
| eav_stb | output | 1 | First clock of the end-of-active code slot |
| err_flags | output | 4 | Sticky configuration error flags |

## Verification
Every output is due on the edge after the inputs that caused it. The counters and all timing outputs describe the new position at that edge. A `cfg_wr` seen at edge k fills the pending set, which first governs the cycle that shows (0,0) after the current frame ends. The error flags follow the governing set on the same edge, and a clear toggle shows zero flags one edge later. The bench steps a reference model exactly once per clock, right after each falling edge, and uses the inputs that were held over the preceding rising edge. It then compares every output at every pixel position of several complete frames, so each of these latencies is checked at its exact cycle.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int HCW      = 13;  // horizontal position width
    localparam int HAW      = 12;  // active width field
    localparam int VCW      = 12;  // vertical position width
    localparam int VSW      = 11;  // vsync end field
    localparam int NERR     = 4;   // number of error flags
    localparam int CODE_LEN = 4;   // clocks in one reference-code slot

    localparam int ERR_EAV_RANGE = 0;
    localparam int ERR_HGEOM     = 1;
    localparam int ERR_VFIT      = 2;
    localparam int ERR_VRANGE    = 3;

    typedef struct packed {
        logic [HCW-1:0] htotal;
        logic [HAW-1:0] hact;
        logic [HCW-1:0] hs_end;
        logic [HCW-1:0] sav;
        logic [HCW-1:0] eav;
        logic [VCW-1:0] vtotal;
        logic [VCW-1:0] vact;
        logic [VSW-1:0] vs_end;
        logic [VCW-1:0] vbi_start;
        logic [VCW-1:0] vbi_end;
    } rtg_cfg_t;

    // Line window [open, close); wraps through zero when open > close.
    function automatic logic in_window(input logic [VCW-1:0] pos,
                                       input logic [VCW-1:0] open,
                                       input logic [VCW-1:0] close);
        if (open <= close)
            return (pos >= open) && (pos < close);
        else
            return (pos >= open) || (pos < close);
    endfunction

endpackage

// File: rtl/rtg_cfg_bank.sv
module rtg_cfg_bank
    import rtg_pkg::*;
#(
    parameter rtg_cfg_t DEF_CFG = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  rtg_cfg_t       wr_cfg_i,
    input  logic           frame_end_i,
    output rtg_cfg_t       act_next_o,
    output logic [HCW-1:0] cur_htotal_o,
    output logic [VCW-1:0] cur_vtotal_o
);

    typedef struct packed {
        rtg_cfg_t act;
        rtg_cfg_t pend;
        logic     pend_vld;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frame_end_i && s_q.pend_vld) begin
            s_d.act      = s_q.pend;
            s_d.pend_vld = 1'b0;
        end
        if (wr_i) begin
            s_d.pend     = wr_cfg_i;
            s_d.pend_vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.act      <= DEF_CFG;
            s_q.pend     <= DEF_CFG;
            s_q.pend_vld <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_next_o   = s_d.act;
    assign cur_htotal_o = s_q.act.htotal;
    assign cur_vtotal_o = s_q.act.vtotal;

    // R7: the active set only moves across a frame boundary
    p_swap_at_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.act) |-> $past(frame_end_i));

    // R7: a waiting set is consumed at the boundary unless rewritten
    p_pend_consumed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && s_q.pend_vld && !wr_i) |=> !s_q.pend_vld);

endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
    parameter int HW = 13,
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] htotal_i,
    input  logic [VW-1:0] vtotal_i,
    output logic [HW-1:0] hcnt_o,
    output logic [VW-1:0] vcnt_o,
    output logic [HW-1:0] hcnt_next_o,
    output logic [VW-1:0] vcnt_next_o,
    output logic          frame_end_o
);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } cnt_t;

    cnt_t c_d, c_q;
    logic h_last, v_last;

    always_comb begin
        h_last = ({1'b0, c_q.h} + {{HW{1'b0}}, 1'b1}) >= {1'b0, htotal_i};
        v_last = ({1'b0, c_q.v} + {{VW{1'b0}}, 1'b1}) >= {1'b0, vtotal_i};
        c_d    = c_q;
        if (h_last) begin
            c_d.h = '0;
            c_d.v = v_last ? '0 : c_q.v + 1'b1;
        end else begin
            c_d.h = c_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign hcnt_o      = c_q.h;
    assign vcnt_o      = c_q.v;
    assign hcnt_next_o = c_d.h;
    assign vcnt_next_o = c_d.v;
    assign frame_end_o = h_last && v_last;

    // R1: the line position returns to zero after its last pixel
    p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        h_last |=> (c_q.h == '0));

    // R1: the line number only moves at the end of a line
    p_vhold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !h_last |=> $stable(c_q.v));

endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
    import rtg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HCW-1:0] h_i,
    input  logic [VCW-1:0] v_i,
    input  logic [HCW-1:0] hs_end_i,
    input  logic [HCW-1:0] sav_i,
    input  logic [HCW-1:0] eav_i,
    input  logic [VSW-1:0] vs_end_i,
    input  logic [VCW-1:0] vbi_start_i,
    input  logic [VCW-1:0] vbi_end_i,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic           vblank_o,
    output logic           de_o,
    output logic           sav_stb_o,
    output logic           eav_stb_o
);

    typedef struct packed {
        logic hsync;
        logic vsync;
        logic vblank;
        logic de;
        logic sav_stb;
        logic eav_stb;
    } out_t;

    out_t o_d, o_q;
    logic [HCW:0] act_open;

    always_comb begin
        act_open    = {1'b0, sav_i} + (HCW+1)'(CODE_LEN);
        o_d.hsync   = h_i < hs_end_i;
        o_d.vsync   = v_i < {{(VCW-VSW){1'b0}}, vs_end_i};
        o_d.vblank  = in_window(v_i, vbi_start_i, vbi_end_i);
        o_d.de      = ({1'b0, h_i} >= act_open) && (h_i < eav_i) && !o_d.vblank;
        o_d.sav_stb = h_i == sav_i;
        o_d.eav_stb = h_i == eav_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign hsync_o   = o_q.hsync;
    assign vsync_o   = o_q.vsync;
    assign vblank_o  = o_q.vblank;
    assign de_o      = o_q.de;
    assign sav_stb_o = o_q.sav_stb;
    assign eav_stb_o = o_q.eav_stb;

    // R6: no pixel is enabled on a blanked line
    p_de_not_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.de |-> !o_q.vblank);

    // R5: the start-code slot precedes active pixels
    p_sav_not_de_r5: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.sav_stb |-> !o_q.de);

endmodule

// File: rtl/rtg_err.sv
module rtg_err
    import rtg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  rtg_cfg_t        cfg_i,
    input  logic            clr_tgl_i,
    output logic [NERR-1:0] flags_o
);

    typedef struct packed {
        logic [NERR-1:0] flags;
        logic            tgl;
    } err_t;

    err_t s_d, s_q;
    logic            toggle;
    logic [NERR-1:0] cond;
    logic [HCW:0]    h_need;
    logic [VCW+1:0]  blank_len;
    logic [VCW+1:0]  v_need;

    always_comb begin
        h_need = {1'b0, cfg_i.sav} + (HCW+1)'(CODE_LEN) + (HCW+1)'(cfg_i.hact);
        if (cfg_i.vbi_start <= cfg_i.vbi_end)
            blank_len = (VCW+2)'(cfg_i.vbi_end) - (VCW+2)'(cfg_i.vbi_start);
        else
            blank_len = (VCW+2)'(cfg_i.vtotal) - (VCW+2)'(cfg_i.vbi_start)
                      + (VCW+2)'(cfg_i.vbi_end);
        v_need = (VCW+2)'(cfg_i.vact) + blank_len;

        cond[ERR_EAV_RANGE] = cfg_i.eav >= cfg_i.htotal;
        cond[ERR_HGEOM]     = (h_need != {1'b0, cfg_i.eav}) || (cfg_i.hs_end > cfg_i.sav);
        cond[ERR_VFIT]      = v_need > (VCW+2)'(cfg_i.vtotal);
        cond[ERR_VRANGE]    = ({{(VCW-VSW){1'b0}}, cfg_i.vs_end} > cfg_i.vtotal)
                           || (cfg_i.vbi_start >= cfg_i.vtotal)
                           || (cfg_i.vbi_end > cfg_i.vtotal);

        toggle    = clr_tgl_i ^ s_q.tgl;
        s_d.tgl   = clr_tgl_i;
        s_d.flags = toggle ? '0 : (s_q.flags | cond);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags_o = s_q.flags;

    // R9: a toggle empties the flag group at the next edge
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> (s_q.flags == '0));

    // R8: without a toggle no flag ever drops
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !toggle |=> ((s_q.flags & $past(s_q.flags)) == $past(s_q.flags)));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int DEF_HTOTAL    = 1344,
    parameter int DEF_HACT      = 1024,
    parameter int DEF_HS_END    = 136,
    parameter int DEF_SAV       = 292,
    parameter int DEF_EAV       = 1320,
    parameter int DEF_VTOTAL    = 625,
    parameter int DEF_VACT      = 600,
    parameter int DEF_VS_END    = 3,
    parameter int DEF_VBI_START = 624,
    parameter int DEF_VBI_END   = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [HCW-1:0]  cfg_htotal,
    input  logic [HAW-1:0]  cfg_hact,
    input  logic [HCW-1:0]  cfg_hs_end,
    input  logic [HCW-1:0]  cfg_sav,
    input  logic [HCW-1:0]  cfg_eav,
    input  logic [VCW-1:0]  cfg_vtotal,
    input  logic [VCW-1:0]  cfg_vact,
    input  logic [VSW-1:0]  cfg_vs_end,
    input  logic [VCW-1:0]  cfg_vbi_start,
    input  logic [VCW-1:0]  cfg_vbi_end,
    input  logic            err_clr_tgl,
    output logic [HCW-1:0]  hcnt,
    output logic [VCW-1:0]  vcnt,
    output logic            hsync,
    output logic            vsync,
    output logic            vblank,
    output logic            de,
    output logic            sav_stb,
    output logic            eav_stb,
    output logic [NERR-1:0] err_flags
);

    localparam rtg_cfg_t DEF_CFG = '{
        htotal:    HCW'(DEF_HTOTAL),
        hact:      HAW'(DEF_HACT),
        hs_end:    HCW'(DEF_HS_END),
        sav:       HCW'(DEF_SAV),
        eav:       HCW'(DEF_EAV),
        vtotal:    VCW'(DEF_VTOTAL),
        vact:      VCW'(DEF_VACT),
        vs_end:    VSW'(DEF_VS_END),
        vbi_start: VCW'(DEF_VBI_START),
        vbi_end:   VCW'(DEF_VBI_END)
    };

    rtg_cfg_t       wr_cfg, act_next;
    logic [HCW-1:0] cur_htotal, h_next;
    logic [VCW-1:0] cur_vtotal, v_next;
    logic           frame_end;

    always_comb begin
        wr_cfg.htotal    = cfg_htotal;
        wr_cfg.hact      = cfg_hact;
        wr_cfg.hs_end    = cfg_hs_end;
        wr_cfg.sav       = cfg_sav;
        wr_cfg.eav       = cfg_eav;
        wr_cfg.vtotal    = cfg_vtotal;
        wr_cfg.vact      = cfg_vact;
        wr_cfg.vs_end    = cfg_vs_end;
        wr_cfg.vbi_start = cfg_vbi_start;
        wr_cfg.vbi_end   = cfg_vbi_end;
    end

    rtg_cfg_bank #(.DEF_CFG(DEF_CFG)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (cfg_wr),
        .wr_cfg_i     (wr_cfg),
        .frame_end_i  (frame_end),
        .act_next_o   (act_next),
        .cur_htotal_o (cur_htotal),
        .cur_vtotal_o (cur_vtotal)
    );

    rtg_counter #(.HW(HCW), .VW(VCW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .htotal_i    (cur_htotal),
        .vtotal_i    (cur_vtotal),
        .hcnt_o      (hcnt),
        .vcnt_o      (vcnt),
        .hcnt_next_o (h_next),
        .vcnt_next_o (v_next),
        .frame_end_o (frame_end)
    );

    rtg_decode u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_i         (h_next),
        .v_i         (v_next),
        .hs_end_i    (act_next.hs_end),
        .sav_i       (act_next.sav),
        .eav_i       (act_next.eav),
        .vs_end_i    (act_next.vs_end),
        .vbi_start_i (act_next.vbi_start),
        .vbi_end_i   (act_next.vbi_end),
        .hsync_o     (hsync),
        .vsync_o     (vsync),
        .vblank_o    (vblank),
        .de_o        (de),
        .sav_stb_o   (sav_stb),
        .eav_stb_o   (eav_stb)
    );

    rtg_err u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (act_next),
        .clr_tgl_i (err_clr_tgl),
        .flags_o   (err_flags)
    );

    // R11: the frame starts with the first line's sync asserted when programmed
    p_frame_start_sync_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && (act_next.vs_end != '0) && (act_next.hs_end != '0))
        |=> (hsync && vsync && hcnt == '0 && vcnt == '0));

endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

    typedef struct {
        int ht, ha, hs, sav, eav, vt, va, vs, vbs, vbe;
    } tcfg_t;

    localparam tcfg_t CA = '{20, 8, 3, 6, 18, 12, 6, 2, 10, 4};   // wrapped blanking
    localparam tcfg_t CB = '{16, 5, 2, 3, 12, 9, 6, 1, 0, 3};     // plain blanking
    localparam tcfg_t CC = '{10, 4, 2, 3, 11, 6, 5, 7, 0, 2};     // flags 1101
    localparam tcfg_t CD = '{16, 6, 2, 3, 12, 9, 6, 1, 0, 3};     // flag 0010

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0;
    logic tgl = 1'b0;
    tcfg_t drv = CA;

    logic [12:0] hcnt;
    logic [11:0] vcnt;
    logic hsync, vsync, vblank, de, sav_stb, eav_stb;
    logic [3:0] err_flags;

    int checks = 0;
    int fails = 0;

    // reference model state
    int m_h, m_v;
    tcfg_t m_act, m_pend;
    bit m_pv;
    logic [3:0] m_flags;
    logic m_tgl;

    always #10 clk = ~clk;

    raster_timing_gen #(
        .DEF_HTOTAL(CA.ht), .DEF_HACT(CA.ha), .DEF_HS_END(CA.hs),
        .DEF_SAV(CA.sav), .DEF_EAV(CA.eav), .DEF_VTOTAL(CA.vt),
        .DEF_VACT(CA.va), .DEF_VS_END(CA.vs), .DEF_VBI_START(CA.vbs),
        .DEF_VBI_END(CA.vbe)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(wr),
        .cfg_htotal(13'(drv.ht)), .cfg_hact(12'(drv.ha)), .cfg_hs_end(13'(drv.hs)),
        .cfg_sav(13'(drv.sav)), .cfg_eav(13'(drv.eav)), .cfg_vtotal(12'(drv.vt)),
        .cfg_vact(12'(drv.va)), .cfg_vs_end(11'(drv.vs)), .cfg_vbi_start(12'(drv.vbs)),
        .cfg_vbi_end(12'(drv.vbe)), .err_clr_tgl(tgl),
        .hcnt(hcnt), .vcnt(vcnt), .hsync(hsync), .vsync(vsync), .vblank(vblank),
        .de(de), .sav_stb(sav_stb), .eav_stb(eav_stb), .err_flags(err_flags)
    );

    function automatic bit win(int v, int s, int e);
        return (s <= e) ? (v >= s && v < e) : (v >= s || v < e);
    endfunction

    function automatic logic [3:0] errs(tcfg_t c);
        logic [3:0] r;
        int blen;
        blen = (c.vbs <= c.vbe) ? c.vbe - c.vbs : c.vt - c.vbs + c.vbe;
        r[0] = c.eav >= c.ht;
        r[1] = (c.sav + 4 + c.ha != c.eav) || (c.hs > c.sav);
        r[2] = c.va + blen > c.vt;
        r[3] = (c.vs > c.vt) || (c.vbs >= c.vt) || (c.vbe > c.vt);
        return r;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at h=%0d v=%0d: actual %0d expected %0d", tag, m_h, m_v, act, exp);
        end
    endtask

    task automatic model_reset();
        m_h = 0; m_v = 0; m_act = CA; m_pend = CA; m_pv = 0;
        m_flags = 4'b0; m_tgl = 1'b0;
    endtask

    task automatic adv();
        if (m_h + 1 >= m_act.ht) begin
            m_h = 0;
            if (m_v + 1 >= m_act.vt) begin
                m_v = 0;
                if (m_pv) begin m_act = m_pend; m_pv = 0; end
            end else m_v++;
        end else m_h++;
        if (wr) begin m_pend = drv; m_pv = 1; end
        if (tgl != m_tgl) m_flags = 4'b0;
        else              m_flags = m_flags | errs(m_act);
        m_tgl = tgl;
    endtask

    task automatic cmp();
        chk(int'(hcnt) == m_h, "R1/R11 hcnt", int'(hcnt), m_h);
        chk(int'(vcnt) == m_v, "R1/R11 vcnt", int'(vcnt), m_v);
        chk(hsync == (m_h < m_act.hs), "R2 hsync", int'(hsync), int'(m_h < m_act.hs));
        chk(vsync == (m_v < m_act.vs), "R3 vsync", int'(vsync), int'(m_v < m_act.vs));
        chk(vblank == win(m_v, m_act.vbs, m_act.vbe), "R4 vblank", int'(vblank),
            int'(win(m_v, m_act.vbs, m_act.vbe)));
        chk(sav_stb == (m_h == m_act.sav), "R5 sav_stb", int'(sav_stb), int'(m_h == m_act.sav));
        chk(eav_stb == (m_h == m_act.eav), "R5 eav_stb", int'(eav_stb), int'(m_h == m_act.eav));
        chk(de == (m_h >= m_act.sav + 4 && m_h < m_act.eav && !win(m_v, m_act.vbs, m_act.vbe)),
            "R6 de", int'(de),
            int'(m_h >= m_act.sav + 4 && m_h < m_act.eav && !win(m_v, m_act.vbs, m_act.vbe)));
        chk(err_flags == m_flags, "R8 err_flags", int'(err_flags), int'(m_flags));
    endtask

    task automatic cyc();
        @(negedge clk);
        adv();
        cmp();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic write_cfg(tcfg_t c);
        drv = c;
        wr = 1'b1;
        cyc();
        wr = 1'b0;
    endtask

    task automatic to_frame_start();
        do cyc(); while (!(m_h == 0 && m_v == 0));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        chk(hcnt == 0 && vcnt == 0, "R10 reset counters", int'(hcnt) + int'(vcnt), 0);
        chk({hsync, vsync, vblank, de, sav_stb, eav_stb} == 6'b0, "R10 reset outputs",
            int'({hsync, vsync, vblank, de, sav_stb, eav_stb}), 0);
        chk(err_flags == 4'b0, "R10 reset flags", int'(err_flags), 0);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int ph, pv;
        do_reset();

        // default set, two whole frames (R1..R6, R11)
        run(2 * CA.ht * CA.vt);

        // R7: two writes mid-frame, the latest wins and the frame completes first
        run(30);
        write_cfg(CD);
        run(20);
        write_cfg(CB);
        ph = 0; pv = 0;
        do begin
            ph = int'(hcnt); pv = int'(vcnt);
            cyc();
        end while (!(m_h == 0 && m_v == 0));
        chk(ph == CA.ht - 1, "R7 old line length kept to boundary", ph, CA.ht - 1);
        chk(pv == CA.vt - 1, "R7 old frame height kept to boundary", pv, CA.vt - 1);
        run(2 * CB.ht * CB.vt);
        chk(err_flags == 4'b0000, "R8 consistent set has no flags", int'(err_flags), 0);

        // R8/R9: inconsistent set
        write_cfg(CC);
        to_frame_start();
        run(3);
        chk(err_flags == 4'b1101, "R8 flags for bad set", int'(err_flags), 13);
        run(CC.ht * CC.vt);
        tgl = ~tgl;
        cyc();
        chk(err_flags == 4'b0000, "R9 cleared by toggle", int'(err_flags), 0);
        cyc();
        chk(err_flags == 4'b1101, "R9 flags return for bad set", int'(err_flags), 13);

        // back to a good set: flags stay until a toggle, then stay clear
        write_cfg(CB);
        to_frame_start();
        run(2);
        chk(err_flags == 4'b1101, "R8 flags sticky after good set", int'(err_flags), 13);
        tgl = ~tgl;
        cyc();
        chk(err_flags == 4'b0000, "R9 cleared by falling toggle", int'(err_flags), 0);
        run(5);
        chk(err_flags == 4'b0000, "R9 stays clear for good set", int'(err_flags), 0);

        // R8: horizontal geometry mismatch alone
        write_cfg(CD);
        to_frame_start();
        run(CD.ht * CD.vt);
        chk(err_flags == 4'b0010, "R8 geometry flag", int'(err_flags), 2);
        tgl = ~tgl;
        cyc();
        write_cfg(CB);
        to_frame_start();
        tgl = ~tgl;
        run(CB.ht * CB.vt);

        // R10: reset mid-frame with a pending write discards it
        write_cfg(CC);
        run(7);
        do_reset();
        run(2 * CA.ht * CA.vt);
        chk(err_flags == 4'b0000, "R10 defaults active after reset", int'(err_flags), 0);

        summary();
        $finish;
    end

endmodule